// File: doc/BRIEF.md
# Edge-Triggered One-Shot Down Counter

This block is one timer channel that runs a single countdown each time an external signal rises. Software arms it with a start strobe. The channel then raises its enable status and waits. It does not count until it sees a rising edge on the asynchronous trigger input. That input is synchronised and can also be filtered, so that short glitches cannot start a count.

When a trigger is detected, the channel copies the reload value into its count register. It then decrements once on every clock where the count-clock enable is high. Once the register is at zero, the next enabled clock raises a one-clock interrupt pulse and parks the register at all ones. The channel then goes back to waiting for the next rising edge, so one arming can serve any number of shots. A stop strobe disarms the channel at any time.

Top module: `edge_oneshot_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, the count output is all ones, the enable status is low and the interrupt is low.
- R2: A start strobe sets the enable status on the next clock, and a stop strobe clears it on the next clock. When both arrive in the same cycle, stop wins.
- R3: While the channel is enabled and no trigger has been detected, the count output holds its value and no interrupt is raised, even with the count-clock enable high.
- R4: With the filter off, a rising trigger input driven before clock edge 1 loads the reload value into the count, visible after edge 4. A reload value of zero is allowed.
- R5: With the filter on, the same stimulus shows the reload value after edge 6 and not earlier. A trigger pulse that lasts only two clocks is ignored.
- R6: While counting, the count falls by exactly one on each clock with the count-clock enable high and holds on clocks where it is low.
- R7: On the first enabled clock after the count reaches zero, the interrupt is high for exactly one cycle and the count is all ones in that same cycle. A reload value N therefore gives the interrupt N+1 enabled clocks after the load.
- R8: After expiry the enable status stays high, and a later rising edge starts another one-shot.
- R9: Rising trigger edges that arrive while a count is in progress do not change the count sequence.
- R10: A stop strobe during a count parks the count at all ones and suppresses the interrupt. While disabled, the count stays all ones.
- R11: A trigger edge while the channel is disabled starts nothing. An input that is already high when the channel is armed does not trigger until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en_i | input | 1 | Count-clock enable; the count moves only when high |
| start_i | input | 1 | One-cycle arm strobe |
| stop_i | input | 1 | One-cycle disarm strobe; has priority over start |
| reload_i | input | CNT_W | Value loaded into the count on a trigger |
| tin_i | input | 1 | Asynchronous external trigger input |
| filt_en_i | input | 1 | Selects the glitch filter on the trigger path |
| count_o | output | CNT_W | Current count register value |
| enabled_o | output | 1 | Channel enable status |
| irq_o | output | 1 | One-cycle expiry interrupt |

## Verification
All inputs are driven and all outputs are sampled on the falling clock edge. The bench keeps its own count of rising edges and computes every expected result from that count. The loaded value is due 4 edges after the trigger input rises, or 6 edges with the filter on. The interrupt is due N+1 enabled edges after that, and the bench adds any clocks where the count-clock enable was held low. A status change after a start or stop strobe is due after one edge. The driver pushes the exact edge number of each expected interrupt into a queue. The monitor pops an entry when the pulse appears, and it reports a pulse that comes early, comes late, is missing or was never expected.

// File: rtl/ost_pkg.sv
// Shared types for the one-shot timer channel.
package ost_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } ost_state_e;
endpackage

// File: rtl/ost_in_cond.sv
// Trigger input conditioning: a synchroniser chain, an optional glitch filter
// that needs FILT_SAMPLES extra agreeing samples, and a rising-edge detector.
// Assumes SYNC_STAGES >= 2 and FILT_SAMPLES >= 1. All logic runs on clk.
module ost_in_cond #(
    parameter int SYNC_STAGES  = 2,
    parameter int FILT_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tin_i,
    input  logic filt_en_i,
    output logic rise_o
);
    localparam int WIN_W = FILT_SAMPLES + 1;

    logic [SYNC_STAGES-1:0]  sync_q;
    logic [FILT_SAMPLES-1:0] hist_q;
    logic [WIN_W-1:0]        window;
    logic                    synced;
    logic                    accepted;
    logic                    clean_q;
    logic                    prev_q;

    assign synced = sync_q[SYNC_STAGES-1];
    assign window = {hist_q, synced};

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], tin_i};
    end

    // Keep the recent history of synchronised samples for the filter.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= window[FILT_SAMPLES-1:0];
    end

    // Filtered level changes only when the whole window agrees.
    always_comb begin
        if (&window)       accepted = 1'b1;
        else if (~|window) accepted = 1'b0;
        else               accepted = clean_q;
    end

    // Register the chosen level and its previous value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            clean_q <= filt_en_i ? accepted : synced;
            prev_q  <= clean_q;
        end
    end

    assign rise_o = clean_q & ~prev_q;
endmodule

// File: rtl/ost_counter.sv
// Count register: park to all ones, load reload value, or decrement.
// Assumes the control never asks for load and decrement in one cycle.
module ost_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park_i,
    input  logic             load_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Update the count; park has priority over load, load over decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '1;
        else if (park_i) cnt_q <= '1;
        else if (load_i) cnt_q <= reload_i;
        else if (dec_i)  cnt_q <= cnt_q - ONE;
    end

    assign count_o = cnt_q;
    assign zero_o  = (cnt_q == '0);
endmodule

// File: rtl/ost_ctrl.sv
// Channel sequencer: off / armed-waiting / running. It issues the counter
// commands and the registered one-cycle expiry interrupt. Stop overrides all.
module ost_ctrl
    import ost_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic rise_i,
    input  logic cnt_en_i,
    input  logic zero_i,
    output logic load_o,
    output logic dec_o,
    output logic park_o,
    output logic enabled_o,
    output logic irq_o
);
    ost_state_e state_q, state_d;
    logic       running;
    logic       expire;
    logic       irq_q;

    assign running = (state_q == ST_RUN);
    assign expire  = running && cnt_en_i && zero_i;

    // Counter commands for this cycle.
    always_comb begin
        load_o = (state_q == ST_ARMED) && rise_i && !stop_i;
        dec_o  = running && cnt_en_i && !zero_i && !stop_i;
        park_o = stop_i || expire;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (stop_i) begin
            state_d = ST_OFF;
        end else begin
            case (state_q)
                ST_OFF:   if (start_i) state_d = ST_ARMED;
                ST_ARMED: if (rise_i)  state_d = ST_RUN;
                ST_RUN:   if (expire)  state_d = ST_ARMED;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // State and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= expire && !stop_i;
        end
    end

    assign enabled_o = (state_q != ST_OFF);
    assign irq_o     = irq_q;
endmodule

// File: rtl/edge_oneshot_timer.sv
// Top of the one-shot channel: input conditioning, sequencer and count
// register. Assumes tin_i may be fully asynchronous to clk.
module edge_oneshot_timer #(
    parameter int CNT_W        = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int FILT_SAMPLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             tin_i,
    input  logic             filt_en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             enabled_o,
    output logic             irq_o
);
    logic rise;
    logic load;
    logic dec;
    logic park;
    logic zero;

    ost_in_cond #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_SAMPLES(FILT_SAMPLES)
    ) in_cond_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tin_i    (tin_i),
        .filt_en_i(filt_en_i),
        .rise_o   (rise)
    );

    ost_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .rise_i   (rise),
        .cnt_en_i (cnt_en_i),
        .zero_i   (zero),
        .load_o   (load),
        .dec_o    (dec),
        .park_o   (park),
        .enabled_o(enabled_o),
        .irq_o    (irq_o)
    );

    ost_counter #(
        .CNT_W(CNT_W)
    ) counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .park_i  (park),
        .load_i  (load),
        .dec_i   (dec),
        .reload_i(reload_i),
        .count_o (count_o),
        .zero_o  (zero)
    );
endmodule

// File: rtl/ost_checker.sv
// Port-level properties of the one-shot channel, bound to the top.
module ost_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en_i,
    input logic             start_i,
    input logic             stop_i,
    input logic [CNT_W-1:0] reload_i,
    input logic [CNT_W-1:0] count_o,
    input logic             enabled_o,
    input logic             irq_o
);
    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R7
    irq_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (count_o == '1 && enabled_o));

    // R2
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !enabled_o);

    // R2
    start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> enabled_o);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled_o && !cnt_en_i) |=>
            (count_o == $past(count_o) || count_o == $past(reload_i) || count_o == '1));

    // R10
    off_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled_o |-> (count_o == '1 && !irq_o));
endmodule

bind edge_oneshot_timer ost_checker #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en_i (cnt_en_i),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .reload_i (reload_i),
    .count_o  (count_o),
    .enabled_o(enabled_o),
    .irq_o    (irq_o)
);

// File: tb/edge_oneshot_timer_tb_top.sv
// Scoreboard bench: the driver queues expected interrupt edges, the monitor
// pops them as pulses appear; direct checks cover count and status.
module edge_oneshot_timer_tb_top;
    localparam int W = 16;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b1;
    logic         start = 1'b0;
    logic         stop = 1'b0;
    logic [W-1:0] reload = '0;
    logic         tin = 1'b0;
    logic         filt_en = 1'b0;
    logic [W-1:0] count;
    logic         enabled;
    logic         irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    int exp_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    edge_oneshot_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en), .start_i(start),
        .stop_i(stop), .reload_i(reload), .tin_i(tin), .filt_en_i(filt_en),
        .count_o(count), .enabled_o(enabled), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_irq(input int at);
        exp_q.push_back(at);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor: match every interrupt pulse against the expected edge number.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                total++; bad++;
                $display("FAIL R7 missing irq act=none exp=%0d", exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (irq) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R7 unexpected irq act=%0d exp=none", cyc);
                end else begin
                    if (exp_q[0] != cyc) begin
                        bad++;
                        $display("FAIL R7 irq timing act=%0d exp=%0d", cyc, exp_q[0]);
                    end
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=end", cyc);
            done = 1'b1;
            finish_run();
        end
    end

    initial begin
        int t;
        step(1);
        chk(count == ONES && !enabled && !irq, "R1", "reset state", int'(count), int'(ONES));
        step(2);
        rst_n = 1'b1;
        step(1);
        chk(count == ONES && !enabled && !irq, "R1", "after reset", int'(count), int'(ONES));

        // R11: trigger while disabled
        tin = 1'b1; reload = 16'd7;
        step(8);
        chk(count == ONES && !enabled, "R11", "edge while off", int'(count), int'(ONES));
        tin = 1'b0;
        step(3);

        // R2 / R3: arm, no trigger yet
        start = 1'b1; step(1); start = 1'b0;
        chk(enabled, "R2", "start arms", int'(enabled), 1);
        step(6);
        chk(count == ONES, "R3", "armed holds", int'(count), int'(ONES));

        // R4 / R6 / R9 / R7: unfiltered shot, reload 5, with a pause
        t = cyc; reload = 16'd5; tin = 1'b1;
        expect_irq(t + 13);
        step(4);
        chk(count == 16'd5, "R4", "load unfiltered", int'(count), 5);
        step(1);
        chk(count == 16'd4, "R6", "decrement", int'(count), 4);
        cnt_en = 1'b0; tin = 1'b0;
        step(2);
        tin = 1'b1;
        step(1);
        chk(count == 16'd4, "R6", "hold without enable", int'(count), 4);
        cnt_en = 1'b1;
        step(2);
        chk(count == 16'd2, "R9", "edge during count ignored", int'(count), 2);
        step(2);
        chk(count == 16'd0, "R6", "reaches zero", int'(count), 0);
        step(1);
        chk(count == ONES, "R7", "parks after expiry", int'(count), int'(ONES));
        chk(enabled, "R8", "stays enabled", int'(enabled), 1);
        step(1);
        chk(!irq, "R7", "single pulse", int'(irq), 0);

        // R8 / R4: second shot, reload zero
        tin = 1'b0;
        step(3);
        t = cyc; reload = 16'd0; tin = 1'b1;
        expect_irq(t + 5);
        step(4);
        chk(count == 16'd0, "R4", "reload zero loads", int'(count), 0);
        step(1);
        chk(count == ONES, "R8", "second shot expired", int'(count), int'(ONES));

        // R5: filter on, glitch then real edge
        filt_en = 1'b1; tin = 1'b0;
        step(6);
        tin = 1'b1; step(2); tin = 1'b0;
        step(8);
        chk(count == ONES, "R5", "glitch ignored", int'(count), int'(ONES));
        t = cyc; reload = 16'd3; tin = 1'b1;
        expect_irq(t + 10);
        step(5);
        chk(count == ONES, "R5", "not loaded early", int'(count), int'(ONES));
        step(1);
        chk(count == 16'd3, "R5", "filtered load", int'(count), 3);
        step(4);
        chk(count == ONES, "R7", "filtered expiry", int'(count), int'(ONES));

        // R10: stop during a count
        filt_en = 1'b0; tin = 1'b0;
        step(3);
        reload = 16'd10; tin = 1'b1;
        step(6);
        chk(count == 16'd8, "R6", "counting before stop", int'(count), 8);
        stop = 1'b1; step(1); stop = 1'b0;
        chk(!enabled, "R2", "stop clears", int'(enabled), 0);
        chk(count == ONES, "R10", "stop parks", int'(count), int'(ONES));
        step(20);
        chk(count == ONES && !enabled, "R10", "no resume after stop", int'(count), int'(ONES));

        // R2: start and stop together
        start = 1'b1; stop = 1'b1; step(1); start = 1'b0; stop = 1'b0;
        chk(!enabled, "R2", "stop wins", int'(enabled), 0);
        start = 1'b1; step(1); start = 1'b0;
        chk(enabled, "R2", "rearm", int'(enabled), 1);

        // R11: input already high at arming
        step(8);
        chk(count == ONES, "R11", "high level no trigger", int'(count), int'(ONES));
        tin = 1'b0;
        step(3);
        t = cyc; reload = 16'd2; tin = 1'b1;
        expect_irq(t + 7);
        step(7);
        chk(count == ONES && enabled, "R8", "shot after rearm", int'(count), int'(ONES));
        step(3);
        chk(exp_q.size() == 0, "R7", "all irqs seen", exp_q.size(), 0);

        done = 1'b1;
        finish_run();
    end
endmodule